// File: doc/BRIEF.md
# Bit-Group Swap Permutation Network

This block is a purely combinational permutation network. It rearranges a data word by exchanging neighbouring groups of bits, where the group sizes are one bit, two bits, four bits and so on up to half the word. A control word holds one enable bit per group size. Together these bits pick which exchanges take place, so one structure covers full bit reversal, byte-order reversal, halfword and word exchange, nibble exchange, bit-pair exchange and the same operations confined to smaller containers.

The network is a chain of stages, one for each control bit. Stage k takes the word from stage k-1. It either passes that word through or exchanges every adjacent pair of 2^k-bit groups in it. The net effect is that result bit j comes from operand bit (j XOR control). An execution unit feeds it an operand and a control value, and reads the permuted word in the same cycle. The data width is a parameter, 32 or 64, and the control width is its base-2 logarithm.

Top module: `bit_group_swapper`

## Requirements
- R1: A control value of 0 returns the operand unchanged.
- R2: For every control value c, result bit j equals operand bit (j XOR c), for all j.
- R3: With a 32-bit width, control 31 reverses the order of all 32 bits (operand bit 0 goes to result bit 31).
- R4: With a 32-bit width, control 24 reverses the byte order of the word (0x12345678 becomes 0x78563412).
- R5: With a 32-bit width, control 7 reverses the bit order inside each byte and leaves the bytes in place.
- R6: With a 32-bit width, control 8 exchanges the two bytes of each halfword (0x12345678 becomes 0x34127856).
- R7: With a 32-bit width, control 16 exchanges the two halfwords. With a 64-bit width, control 32 exchanges the two 32-bit words.
- R8: Passing the result through the network again with the same control value restores the original operand.
- R9: The number of set bits in the result equals the number of set bits in the operand.
- R10: A control value with only bit k set exchanges each adjacent pair of 2^k-bit groups. Control 4 turns 0x12345678 into 0x21436587, and control 1 turns 0xA into 0x5.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| data_i | input | W_DATA | Operand to permute |
| ctrl_i | input | $clog2(W_DATA) | Stage enables; bit k exchanges adjacent 2^k-bit groups |
| data_o | output | W_DATA | Permuted word |

## Verification
The hardest case to reach is a control value that turns on several non-adjacent stages together. In that case a wrong mask or a misordered stage in one stage can hide behind another stage. The stimulus therefore sweeps every control value, from 0 to 2^CTRL_W-1, over several random operands. Each result is compared bit by bit against the XOR-index rule. A second copy of the network is fed the first copy's result with the same control, and it must give back the operand. Operands with only one bit set catch any bit that lands in the wrong place.

// File: rtl/group_swap_pkg.sv
package group_swap_pkg;
  // Width in bits of the groups exchanged by stage `lvl`.
  function automatic int unsigned stage_group(input int unsigned lvl);
    return 32'd1 << lvl;
  endfunction
endpackage

// File: rtl/swap_mask_gen.sv
// Constant mask: bit j set when j sits in the lower group of its pair.
module swap_mask_gen #(
  parameter int unsigned W     = 32,
  parameter int unsigned GROUP = 1
) (
  output logic [W-1:0] mask_o
);
  for (genvar j = 0; j < W; j++) begin : g_bit
    assign mask_o[j] = (((j / GROUP) % 2) == 0);
  end
endmodule

// File: rtl/group_swap_stage.sv
// One 2:1 mux layer: pass through or exchange adjacent GROUP-bit groups.
module group_swap_stage #(
  parameter int unsigned W     = 32,
  parameter int unsigned LEVEL = 0
) (
  input  logic [W-1:0] d_i,
  input  logic         en_i,
  output logic [W-1:0] d_o
);
  localparam int unsigned GROUP = group_swap_pkg::stage_group(LEVEL);

  logic [W-1:0] low_m;
  logic [W-1:0] exchanged;

  swap_mask_gen #(.W(W), .GROUP(GROUP)) u_mask (.mask_o(low_m));

  always_comb begin
    exchanged = ((d_i & low_m) << GROUP) | ((d_i >> GROUP) & low_m);
    d_o       = en_i ? exchanged : d_i;
  end
endmodule

// File: rtl/bit_group_swapper.sv
module bit_group_swapper #(
  parameter int unsigned W_DATA = 32,
  localparam int unsigned CTRL_W = $clog2(W_DATA)
) (
  input  logic [W_DATA-1:0] data_i,
  input  logic [CTRL_W-1:0] ctrl_i,
  output logic [W_DATA-1:0] data_o
);
  logic [W_DATA-1:0] chain [CTRL_W+1];

  assign chain[0] = data_i;

  // Stages run from the smallest group size upward.
  for (genvar k = 0; k < CTRL_W; k++) begin : g_stage
    group_swap_stage #(.W(W_DATA), .LEVEL(k)) u_stage (
      .d_i (chain[k]),
      .en_i(ctrl_i[k]),
      .d_o (chain[k+1])
    );
  end

  assign data_o = chain[CTRL_W];
endmodule

// File: rtl/bit_group_swapper_chk.sv
module bit_group_swapper_chk #(
  parameter int unsigned W_DATA = 32,
  parameter int unsigned CTRL_W = 5
) (
  input logic [W_DATA-1:0] data_i,
  input logic [CTRL_W-1:0] ctrl_i,
  input logic [W_DATA-1:0] data_o
);
  always_comb begin
    assert_identity_R1: assert (ctrl_i != '0 || data_o == data_i)
      else $error("R1: zero control altered operand");
    assert_low_bit_R2: assert (data_o[0] == data_i[ctrl_i])
      else $error("R2: result bit 0 not taken from operand bit ctrl");
    assert_high_bit_R2: assert (data_o[W_DATA-1] == data_i[(W_DATA-1) ^ ctrl_i])
      else $error("R2: result top bit has wrong source");
    assert_popcount_R9: assert ($countones(data_o) == $countones(data_i))
      else $error("R9: set-bit count changed");
  end
endmodule

bind bit_group_swapper bit_group_swapper_chk #(
  .W_DATA(W_DATA), .CTRL_W(CTRL_W)
) u_chk (
  .data_i(data_i), .ctrl_i(ctrl_i), .data_o(data_o)
);

// File: tb/bit_group_swapper_test.sv
module bit_group_swapper_test;
  logic clk;
  logic rst_n;
  int   checks;
  int   fails;
  bit   finished;

  logic [31:0] din, dout, dback;
  logic [4:0]  ctl;
  logic [63:0] din64, dout64;
  logic [5:0]  ctl64;

  bit_group_swapper #(.W_DATA(32)) uut    (.data_i(din),  .ctrl_i(ctl),   .data_o(dout));
  bit_group_swapper #(.W_DATA(32)) uut_rt (.data_i(dout), .ctrl_i(ctl),   .data_o(dback));
  bit_group_swapper #(.W_DATA(64)) uut64  (.data_i(din64),.ctrl_i(ctl64), .data_o(dout64));

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // {ctrl, operand, expected}, all for 32-bit width
  localparam logic [68:0] VEC [10] = '{
    {5'd0,  32'h12345678, 32'h12345678},  // R1
    {5'd31, 32'h00000001, 32'h80000000},  // R3
    {5'd31, 32'h12345678, 32'h1E6A2C48},  // R3
    {5'd24, 32'h12345678, 32'h78563412},  // R4
    {5'd7,  32'h01020380, 32'h8040C001},  // R5
    {5'd8,  32'h12345678, 32'h34127856},  // R6
    {5'd16, 32'h12345678, 32'h56781234},  // R7
    {5'd4,  32'h12345678, 32'h21436587},  // R10
    {5'd1,  32'h0000000A, 32'h00000005},  // R10
    {5'd2,  32'h0000000C, 32'h00000003}   // R10
  };
  localparam string VEC_REQ [10] = '{"R1","R3","R3","R4","R5","R6","R7","R10","R10","R10"};

  function automatic logic [31:0] xor_index(input logic [31:0] v, input logic [4:0] c);
    logic [31:0] r;
    for (int j = 0; j < 32; j++) r[j] = v[j ^ int'(c)];
    return r;
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    checks = 0; fails = 0; finished = 1'b0;
    rst_n = 1'b0;
    din = 32'hCAFEF00D; ctl = '0; din64 = '0; ctl64 = '0;
    repeat (2) @(negedge clk);
    check("R1", {32'b0, dout}, {32'b0, 32'hCAFEF00D});  // during reset
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < 10; i++) begin
      ctl = VEC[i][68:64];
      din = VEC[i][63:32];
      @(negedge clk);
      check(VEC_REQ[i], {32'b0, dout}, {32'b0, VEC[i][31:0]});
      check("R8", {32'b0, dback}, {32'b0, din});
    end

    // R2 / R8 / R9: every control value over random operands
    for (int c = 0; c < 32; c++) begin
      for (int n = 0; n < 6; n++) begin
        ctl = 5'(c);
        din = (n == 0) ? (32'h1 << c) : $urandom;
        @(negedge clk);
        check("R2", {32'b0, dout}, {32'b0, xor_index(din, ctl)});
        check("R8", {32'b0, dback}, {32'b0, din});
        check("R9", 64'($countones(dout)), 64'($countones(din)));
      end
    end

    // R7 at 64-bit width
    ctl64 = 6'd32; din64 = 64'h0123456789ABCDEF;
    @(negedge clk);
    check("R7", dout64, 64'h89ABCDEF01234567);
    ctl64 = 6'd0;
    @(negedge clk);
    check("R1", dout64, 64'h0123456789ABCDEF);
    ctl64 = 6'd63; din64 = 64'h1;
    @(negedge clk);
    check("R3", dout64, 64'h8000000000000000);

    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule